// File: doc/BRIEF.md
# Context-Banked Carry/Zero Flag Unit

This unit keeps the carry and zero condition flags of a small 8-bit core in three separate pairs: one for ordinary program flow, one for maskable interrupt service and one for non-maskable interrupt service. Entering a service routine does not save the flags anywhere. The unit switches to the pair that belongs to the new context, and the pair it leaves keeps its values unchanged. A return-from-interrupt strobe switches back to the context that was interrupted. A short history of the interrupted contexts lets an NMI taken during a maskable-interrupt routine return first to that routine and then to normal flow.

The ALU reports a new carry and a new zero, each with its own write enable. The carry is set on a carry or borrow and otherwise cleared, or it takes the tested bit on a bit test. The zero is set when the last arithmetic or logic result was zero. Reads and writes always reach only the pair of the current context. After reset the unit is in NMI context, so the NMI pair is in use first.

Top module: `cz_ctx_flags`

## Requirements
- R1: After reset the context is NMI and the carry and zero outputs are both 0. Every flag in every pair resets to 0.
- R2: `ctx_o` encodes the context as 2'b00 normal, 2'b01 maskable interrupt and 2'b10 NMI. The value 2'b11 never appears.
- R3: A maskable-interrupt entry strobe in normal context moves the unit to interrupt context from the next cycle. In interrupt or NMI context the strobe has no effect.
- R4: An NMI entry strobe in normal or interrupt context moves the unit to NMI context from the next cycle. In NMI context the strobe has no effect.
- R5: A return strobe restores the context that the most recent accepted entry interrupted, so that normal→interrupt→NMI returns through interrupt context and then to normal context. In interrupt or NMI context with no recorded history, a return strobe goes to normal context.
- R6: A return strobe in normal context leaves the context and the flag outputs unchanged.
- R7: With `carry_we` high, `alu_carry` is written to the carry of the current pair and appears on `carry_o` from the next cycle. `zero_we` and `alu_zero` do the same for the zero flag, independently of the carry.
- R8: A write changes only the pair of the current context. A context switch clears no flag, and a pair shows its last written values whenever its context becomes active again.
- R9: When several strobes arrive in one cycle, NMI entry wins over interrupt entry, which wins over return. A flag write in the same cycle as a context switch lands in the pair that was active before the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_entry | input | 1 | Maskable interrupt taken (one-cycle strobe) |
| nmi_entry | input | 1 | NMI taken (one-cycle strobe) |
| reti | input | 1 | Return from interrupt executed (one-cycle strobe) |
| carry_we | input | 1 | Write enable for the carry flag |
| alu_carry | input | 1 | New carry value from the ALU |
| zero_we | input | 1 | Write enable for the zero flag |
| alu_zero | input | 1 | New zero value from the ALU |
| carry_o | output | 1 | Carry of the active pair |
| zero_o | output | 1 | Zero of the active pair |
| ctx_o | output | 2 | Current context (see R2) |

## Verification
A wrong context register shows on `ctx_o` one cycle after the strobe that caused it. A wrong bank selection shows only when the affected pair is read, which can be many cycles later after a return. For that reason the directed scenarios write distinct flag patterns in each context and read them back after every switch and return. A corrupted history entry stays hidden until the second return of a nested sequence, so the nested interrupt-then-NMI path is walked all the way back to normal context.

// File: rtl/cz_ctx_pkg.sv
package cz_ctx_pkg;
    localparam int NUM_CTX = 3;

    typedef enum logic [1:0] {
        CTX_BASE = 2'd0,
        CTX_IRQ  = 2'd1,
        CTX_NMI  = 2'd2
    } ctx_e;
endpackage

// File: rtl/cz_flag_pair.sv
// One carry/zero pair. It is updated only while its context is selected.
module cz_flag_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic c_we,
    input  logic c_in,
    input  logic z_we,
    input  logic z_in,
    output logic c_q,
    output logic z_q
);
    typedef struct packed {
        logic c;
        logic z;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel && c_we) st_d.c = c_in;
        if (sel && z_we) st_d.z = z_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_q = st_q.c;
    assign z_q = st_q.z;
endmodule

// File: rtl/cz_ctx_track.sv
// Tracks the current context and a stack of the contexts that were interrupted.
module cz_ctx_track
    import cz_ctx_pkg::*;
#(
    parameter int HIST_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_entry,
    input  logic nmi_entry,
    input  logic reti,
    output ctx_e ctx_q_o
);
    localparam int DW = $clog2(HIST_DEPTH + 1);

    typedef struct packed {
        ctx_e                  ctx;
        ctx_e [HIST_DEPTH-1:0] hist;
        logic [DW-1:0]         depth;
    } trk_t;

    trk_t st_d, st_q;
    logic push, pop;
    ctx_e new_ctx;
    ctx_e prev_ctx;

    // NMI entry > IRQ entry > return
    always_comb begin
        push    = 1'b0;
        pop     = 1'b0;
        new_ctx = st_q.ctx;
        if (nmi_entry && st_q.ctx != CTX_NMI) begin
            push    = 1'b1;
            new_ctx = CTX_NMI;
        end else if (irq_entry && st_q.ctx == CTX_BASE) begin
            push    = 1'b1;
            new_ctx = CTX_IRQ;
        end else if (reti && st_q.ctx != CTX_BASE) begin
            pop = 1'b1;
        end
    end

    always_comb begin
        prev_ctx = CTX_BASE;
        for (int i = 0; i < HIST_DEPTH; i++) begin
            if (st_q.depth == DW'(i + 1)) prev_ctx = st_q.hist[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            for (int i = 0; i < HIST_DEPTH; i++) begin
                if (st_q.depth == DW'(i)) st_d.hist[i] = st_q.ctx;
            end
            if (st_q.depth != DW'(HIST_DEPTH)) st_d.depth = st_q.depth + 1'b1;
            st_d.ctx = new_ctx;
        end else if (pop) begin
            st_d.ctx = prev_ctx;
            if (st_q.depth != '0) st_d.depth = st_q.depth - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctx   <= CTX_NMI;
            st_q.hist  <= '0;
            st_q.depth <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctx_q_o = st_q.ctx;
endmodule

// File: rtl/cz_ctx_flags.sv
module cz_ctx_flags
    import cz_ctx_pkg::*;
#(
    parameter int HIST_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_entry,
    input  logic       nmi_entry,
    input  logic       reti,
    input  logic       carry_we,
    input  logic       alu_carry,
    input  logic       zero_we,
    input  logic       alu_zero,
    output logic       carry_o,
    output logic       zero_o,
    output logic [1:0] ctx_o
);
    ctx_e               cur_ctx;
    logic [NUM_CTX-1:0] c_vec;
    logic [NUM_CTX-1:0] z_vec;

    cz_ctx_track #(.HIST_DEPTH(HIST_DEPTH)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_entry (irq_entry),
        .nmi_entry (nmi_entry),
        .reti      (reti),
        .ctx_q_o   (cur_ctx)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_bank
        cz_flag_pair u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (cur_ctx == ctx_e'(g)),
            .c_we  (carry_we),
            .c_in  (alu_carry),
            .z_we  (zero_we),
            .z_in  (alu_zero),
            .c_q   (c_vec[g]),
            .z_q   (z_vec[g])
        );
    end

    always_comb begin
        carry_o = 1'b0;
        zero_o  = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (cur_ctx == ctx_e'(i)) begin
                carry_o = c_vec[i];
                zero_o  = z_vec[i];
            end
        end
    end

    assign ctx_o = cur_ctx;
endmodule

// File: rtl/cz_ctx_flags_chk.sv
module cz_ctx_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_entry,
    input logic       nmi_entry,
    input logic       reti,
    input logic       carry_we,
    input logic       alu_carry,
    input logic       zero_we,
    input logic       alu_zero,
    input logic       carry_o,
    input logic       zero_o,
    input logic [1:0] ctx_o
);
    // R2
    ctx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_o != 2'b11);

    // R3
    irq_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_o == 2'b00 && irq_entry && !nmi_entry) |=> ctx_o == 2'b01);

    // R3
    irq_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_o != 2'b00 && irq_entry && !nmi_entry && !reti) |=> $stable(ctx_o));

    // R4
    nmi_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_entry |=> ctx_o == 2'b10);

    // R6
    reti_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_o == 2'b00 && reti && !irq_entry && !nmi_entry) |=> ctx_o == 2'b00);

    // R7
    carry_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !irq_entry && !nmi_entry && !reti) |=> carry_o == $past(alu_carry));

    // R7
    zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_we && !irq_entry && !nmi_entry && !reti) |=> zero_o == $past(alu_zero));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_we && !zero_we && !irq_entry && !nmi_entry && !reti)
        |=> ($stable(carry_o) && $stable(zero_o) && $stable(ctx_o)));
endmodule

bind cz_ctx_flags cz_ctx_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_entry (irq_entry),
    .nmi_entry (nmi_entry),
    .reti      (reti),
    .carry_we  (carry_we),
    .alu_carry (alu_carry),
    .zero_we   (zero_we),
    .alu_zero  (alu_zero),
    .carry_o   (carry_o),
    .zero_o    (zero_o),
    .ctx_o     (ctx_o)
);

// File: tb/cz_ctx_flags_test.sv
module cz_ctx_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_entry = 1'b0, nmi_entry = 1'b0, reti = 1'b0;
    logic       carry_we = 1'b0, alu_carry = 1'b0, zero_we = 1'b0, alu_zero = 1'b0;
    logic       carry_o, zero_o;
    logic [1:0] ctx_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cz_ctx_flags uut (
        .clk(clk), .rst_n(rst_n), .irq_entry(irq_entry), .nmi_entry(nmi_entry),
        .reti(reti), .carry_we(carry_we), .alu_carry(alu_carry), .zero_we(zero_we),
        .alu_zero(alu_zero), .carry_o(carry_o), .zero_o(zero_o), .ctx_o(ctx_o)
    );

    // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
    task automatic apply(input logic irq, input logic nmi, input logic ret,
                         input logic cwe, input logic c, input logic zwe, input logic z);
        irq_entry = irq; nmi_entry = nmi; reti = ret;
        carry_we = cwe; alu_carry = c; zero_we = zwe; alu_zero = z;
        @(negedge clk);
        irq_entry = 1'b0; nmi_entry = 1'b0; reti = 1'b0;
        carry_we = 1'b0; alu_carry = 1'b0; zero_we = 1'b0; alu_zero = 1'b0;
    endtask

    task automatic check(input logic [1:0] ctx_e, input logic c_e, input logic z_e,
                         input string tag);
        n_cmp++;
        if (ctx_o !== ctx_e || carry_o !== c_e || zero_o !== z_e) begin
            n_bad++;
            $display("FAIL %s: ctx=%0d c=%0b z=%0b expected ctx=%0d c=%0b z=%0b",
                     tag, ctx_o, carry_o, zero_o, ctx_e, c_e, z_e);
        end
    endtask

    task automatic t_reset;
        check(2'b10, 1'b0, 1'b0, "R1 reset state in NMI context");
    endtask

    task automatic t_first_pair;
        apply(0, 0, 0, 1, 1, 1, 0);
        check(2'b10, 1'b1, 1'b0, "R7 write both flags in NMI pair");
        apply(0, 0, 0, 0, 0, 1, 1);
        check(2'b10, 1'b1, 1'b1, "R7 zero-only write keeps carry");
        apply(0, 0, 1, 0, 0, 0, 0);
        check(2'b00, 1'b0, 1'b0, "R5 empty-history return goes normal, R8 normal pair untouched");
        apply(0, 0, 1, 0, 0, 0, 0);
        check(2'b00, 1'b0, 1'b0, "R6 return in normal context ignored");
    endtask

    task automatic t_nested;
        apply(0, 0, 0, 1, 0, 1, 1);
        check(2'b00, 1'b0, 1'b1, "R7 write in normal pair");
        apply(1, 0, 0, 0, 0, 0, 0);
        check(2'b01, 1'b0, 1'b0, "R3 interrupt entry, R8 fresh interrupt pair");
        apply(0, 0, 0, 1, 1, 1, 1);
        check(2'b01, 1'b1, 1'b1, "R7 write in interrupt pair");
        apply(1, 0, 0, 0, 0, 0, 0);
        check(2'b01, 1'b1, 1'b1, "R3 interrupt entry ignored in interrupt context");
        apply(0, 1, 0, 0, 0, 0, 0);
        check(2'b10, 1'b1, 1'b1, "R4 NMI from interrupt, R8 NMI pair kept its values");
        apply(0, 0, 0, 1, 0, 1, 0);
        check(2'b10, 1'b0, 1'b0, "R7 write in NMI pair");
        apply(1, 0, 0, 0, 0, 0, 0);
        check(2'b10, 1'b0, 1'b0, "R3 interrupt entry ignored in NMI context");
        apply(0, 1, 0, 0, 0, 0, 0);
        check(2'b10, 1'b0, 1'b0, "R4 NMI entry ignored in NMI context");
        apply(0, 0, 1, 0, 0, 0, 0);
        check(2'b01, 1'b1, 1'b1, "R5 return to interrupt context, R8 its pair intact");
        apply(0, 0, 1, 0, 0, 0, 0);
        check(2'b00, 1'b0, 1'b1, "R5 return to normal context, R8 its pair intact");
    endtask

    task automatic t_priority;
        apply(1, 1, 1, 1, 1, 0, 0);
        check(2'b10, 1'b0, 1'b0, "R9 NMI wins, write did not reach NMI pair");
        apply(0, 0, 1, 0, 0, 0, 0);
        check(2'b00, 1'b1, 1'b1, "R9 write landed in normal pair");
        apply(1, 0, 1, 0, 0, 0, 0);
        check(2'b01, 1'b1, 1'b1, "R9 interrupt entry wins over return");
        apply(0, 0, 1, 0, 0, 1, 0);
        check(2'b00, 1'b1, 1'b1, "R9 zero write on return went to interrupt pair");
        apply(1, 0, 0, 0, 0, 0, 0);
        check(2'b01, 1'b1, 1'b0, "R8 interrupt pair shows zero written during return");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(2'b10, 1'b0, 1'b0, "R1 outputs held in reset");
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_pair();
        t_nested();
        t_priority();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule